// File: doc/BRIEF.md
# Tape Format Pattern Duration Detector

This block sits behind the pattern decoders of a tape read channel. Each bit cell, the decoders report three flags: a noise pattern, a burst (block) pattern and a tape-mark pattern. The block measures how long each flag has stayed true without a break. When a flag's run reaches a minimum length, the block sets a sticky status bit for that flag. The minimum length depends on the recording density (6250 or 1600 BPI) and on whether the channel is writing or reading. All runs are counted in half-cell ticks, so the 12.5-cell burst threshold is handled exactly. A tick is any clock cycle in which either the bit-cell strobe or the half-cell strobe is high. The two strobes never coincide, so each cell gives two ticks.

Each of the three flags has its own run tracker, built as a four-state machine:
- OFF: read-OK is low; the status is clear.
- WAIT: no run is in progress.
- RUN: a run is being counted.
- HIT: the status is set and held.

Transitions:
- OFF or WAIT goes to RUN on a tick that sees the flag high while a density is selected.
- RUN goes back to WAIT whenever the flag is low or no density is selected.
- RUN goes to HIT on the tick that brings the count to the threshold. The count saturates there.
- HIT holds until read-OK drops.
- Any state goes to OFF while read-OK is low.

Top module: `tape_pattern_detect`

## Requirements
- R1: The noise status sets after a continuous noise run of 92 half-cell ticks when writing at 6250 BPI, 44 when reading at 6250 BPI, 46 when writing at 1600 BPI and 22 when reading at 1600 BPI.
- R2: The burst status sets after a continuous burst run of 50 half-cell ticks at 6250 BPI and 25 at 1600 BPI, for both write and read.
- R3: The tape-mark status sets after a continuous tape-mark run of 608 half-cell ticks when writing at 6250 BPI, 84 when reading at 6250 BPI, 168 when writing at 1600 BPI and 42 when reading at 1600 BPI.
- R4: While `read_ok` is low, all three status bits read 0 from the next clock edge on, and flags and ticks have no effect.
- R5: Once a status bit is set, it stays 1 while `read_ok` stays high, whatever its flag does afterwards.
- R6: With both `dens_6250` and `dens_1600` low (800 BPI NRZ), no status bit ever sets.
- R7: A clock cycle with the flag low discards that flag's run, so the next run counts from zero.
- R8: With both density bits high, the 6250 BPI thresholds apply.
- R9: A tick is a cycle with `cell_tick` or `half_tick` high. The status becomes visible right after the clock edge of the tick that completes the run.
- R10: The three trackers are independent. A run on one flag never sets another flag's status.
- R11: During and right after reset, all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_tick | input | 1 | Bit-cell strobe, one tick |
| half_tick | input | 1 | Mid-cell strobe, one tick |
| write_mode | input | 1 | 1 = write, 0 = read thresholds |
| dens_6250 | input | 1 | 6250 BPI select (wins if both set) |
| dens_1600 | input | 1 | 1600 BPI select |
| read_ok | input | 1 | Enable; low clears and holds status at 0 |
| noise_flag | input | 1 | Noise pattern seen this cell |
| burst_flag | input | 1 | Burst pattern seen this cell |
| tmark_flag | input | 1 | Tape-mark pattern seen this cell |
| noise_seen | output | 1 | Sticky noise status |
| burst_seen | output | 1 | Sticky burst status |
| tmark_seen | output | 1 | Sticky tape-mark status |

## Verification
Every threshold is probed one tick short and then exactly on the tick. An off-by-one counter, a swapped write/read choice or a threshold counted in whole cells would set early or late. A run broken by a single low cycle must start again from zero; a design that only pauses its count would set after the second partial run. The bench also checks several failure modes:
- a design without true stickiness would drop its status when the flag falls;
- a design that let the 1600 select win when both density bits are set would set at the shorter read threshold;
- a design that ignored the missing density would set during the long 800 BPI run.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
    typedef enum logic [1:0] {
        RS_OFF  = 2'd0,
        RS_WAIT = 2'd1,
        RS_RUN  = 2'd2,
        RS_HIT  = 2'd3
    } run_state_t;

    localparam int NUM_PAT = 3;
    localparam int PAT_NOISE = 0;
    localparam int PAT_BURST = 1;
    localparam int PAT_TMARK = 2;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/tpd_thresh_sel.sv
module tpd_thresh_sel #(
    parameter int CNT_W   = 10,
    parameter int NZ_W65  = 92,
    parameter int NZ_R65  = 44,
    parameter int NZ_W16  = 46,
    parameter int NZ_R16  = 22,
    parameter int BK_65   = 50,
    parameter int BK_16   = 25,
    parameter int TM_W65  = 608,
    parameter int TM_R65  = 84,
    parameter int TM_W16  = 168,
    parameter int TM_R16  = 42
) (
    input  logic                                    write_mode,
    input  logic                                    dens_6250,
    input  logic                                    dens_1600,
    output logic [tpd_pkg::NUM_PAT-1:0][CNT_W-1:0]  thr,
    output logic                                    dens_ok
);
    import tpd_pkg::*;

    always_comb begin
        dens_ok = dens_6250 | dens_1600;
        if (dens_6250) begin
            thr[PAT_NOISE] = write_mode ? CNT_W'(NZ_W65) : CNT_W'(NZ_R65);
            thr[PAT_BURST] = CNT_W'(BK_65);
            thr[PAT_TMARK] = write_mode ? CNT_W'(TM_W65) : CNT_W'(TM_R65);
        end else begin
            thr[PAT_NOISE] = write_mode ? CNT_W'(NZ_W16) : CNT_W'(NZ_R16);
            thr[PAT_BURST] = CNT_W'(BK_16);
            thr[PAT_TMARK] = write_mode ? CNT_W'(TM_W16) : CNT_W'(TM_R16);
        end
    end
endmodule

// File: rtl/tpd_run_fsm.sv
module tpd_run_fsm #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             read_ok,
    input  logic             dens_ok,
    input  logic             tick,
    input  logic             flag,
    input  logic [CNT_W-1:0] thr,
    output logic             seen
);
    import tpd_pkg::*;

    run_state_t       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W:0]   cnt_inc;
    logic             live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        live    = dens_ok & flag;
        nxt     = state;
        cnt_nxt = cnt;
        if (!read_ok) begin
            nxt     = RS_OFF;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                RS_OFF, RS_WAIT: begin
                    cnt_nxt = '0;
                    nxt     = RS_WAIT;
                    if (live && tick) begin
                        if (thr <= CNT_W'(1)) begin
                            nxt     = RS_HIT;
                            cnt_nxt = thr;
                        end else begin
                            nxt     = RS_RUN;
                            cnt_nxt = CNT_W'(1);
                        end
                    end
                end
                RS_RUN: begin
                    if (!live) begin
                        nxt     = RS_WAIT;
                        cnt_nxt = '0;
                    end else if (tick) begin
                        if (cnt_inc >= {1'b0, thr}) begin
                            nxt     = RS_HIT;
                            cnt_nxt = thr;
                        end else begin
                            cnt_nxt = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                RS_HIT: begin
                    nxt = RS_HIT;
                end
            endcase
        end
    end

    always_comb begin
        seen = (state == RS_HIT);
    end
endmodule

// File: rtl/tape_pattern_detect.sv
module tape_pattern_detect #(
    parameter int NZ_W65 = 92,
    parameter int NZ_R65 = 44,
    parameter int NZ_W16 = 46,
    parameter int NZ_R16 = 22,
    parameter int BK_65  = 50,
    parameter int BK_16  = 25,
    parameter int TM_W65 = 608,
    parameter int TM_R65 = 84,
    parameter int TM_W16 = 168,
    parameter int TM_R16 = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_tick,
    input  logic half_tick,
    input  logic write_mode,
    input  logic dens_6250,
    input  logic dens_1600,
    input  logic read_ok,
    input  logic noise_flag,
    input  logic burst_flag,
    input  logic tmark_flag,
    output logic noise_seen,
    output logic burst_seen,
    output logic tmark_seen
);
    import tpd_pkg::*;

    localparam int MAX_NZ  = max4(NZ_W65, NZ_R65, NZ_W16, NZ_R16);
    localparam int MAX_TM  = max4(TM_W65, TM_R65, TM_W16, TM_R16);
    localparam int MAX_THR = max4(MAX_NZ, MAX_TM, BK_65, BK_16);
    localparam int CNT_W   = $clog2(MAX_THR + 1);

    logic [NUM_PAT-1:0][CNT_W-1:0] thr;
    logic                          dens_ok;
    logic                          tick;
    logic [NUM_PAT-1:0]            flags;
    logic [NUM_PAT-1:0]            seen;

    assign tick  = cell_tick | half_tick;
    assign flags = {tmark_flag, burst_flag, noise_flag};

    tpd_thresh_sel #(
        .CNT_W(CNT_W),
        .NZ_W65(NZ_W65), .NZ_R65(NZ_R65), .NZ_W16(NZ_W16), .NZ_R16(NZ_R16),
        .BK_65(BK_65), .BK_16(BK_16),
        .TM_W65(TM_W65), .TM_R65(TM_R65), .TM_W16(TM_W16), .TM_R16(TM_R16)
    ) u_sel (
        .write_mode (write_mode),
        .dens_6250  (dens_6250),
        .dens_1600  (dens_1600),
        .thr        (thr),
        .dens_ok    (dens_ok)
    );

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_trk
        tpd_run_fsm #(.CNT_W(CNT_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .read_ok (read_ok),
            .dens_ok (dens_ok),
            .tick    (tick),
            .flag    (flags[g]),
            .thr     (thr[g]),
            .seen    (seen[g])
        );
    end

    assign noise_seen = seen[PAT_NOISE];
    assign burst_seen = seen[PAT_BURST];
    assign tmark_seen = seen[PAT_TMARK];
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker (
    input logic clk,
    input logic rst_n,
    input logic cell_tick,
    input logic half_tick,
    input logic dens_6250,
    input logic dens_1600,
    input logic read_ok,
    input logic noise_flag,
    input logic burst_flag,
    input logic tmark_flag,
    input logic noise_seen,
    input logic burst_seen,
    input logic tmark_seen
);
    logic [2:0] fl, st;
    assign fl = {tmark_flag, burst_flag, noise_flag};
    assign st = {tmark_seen, burst_seen, noise_seen};

    for (genvar g = 0; g < 3; g++) begin : g_chk
        // R4: read_ok low clears the status at the next edge
        assert_clear_on_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !read_ok |=> !st[g]);
        // R5: a set status holds while read_ok stays high
        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] && read_ok) |=> st[g]);
        // R9 / R10: a status only rises on a tick that sees its own flag
        assert_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st[g]) |-> $past((cell_tick || half_tick) && fl[g] && read_ok));
        // R6: no status rises without a density selected
        assert_no_set_nrz_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st[g]) |-> $past(dens_6250 || dens_1600));
    end
endmodule

bind tape_pattern_detect tpd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_tick  (cell_tick),
    .half_tick  (half_tick),
    .dens_6250  (dens_6250),
    .dens_1600  (dens_1600),
    .read_ok    (read_ok),
    .noise_flag (noise_flag),
    .burst_flag (burst_flag),
    .tmark_flag (tmark_flag),
    .noise_seen (noise_seen),
    .burst_seen (burst_seen),
    .tmark_seen (tmark_seen)
);

// File: tb/tb_tape_pattern_detect.sv
module tb_tape_pattern_detect;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_tick = 1'b0, half_tick = 1'b0;
    logic write_mode = 1'b0, dens_6250 = 1'b0, dens_1600 = 1'b0;
    logic read_ok = 1'b0;
    logic [2:0] fl = 3'b000;
    logic noise_seen, burst_seen, tmark_seen;
    logic [2:0] sn;
    logic phase = 1'b0;
    logic done = 1'b0;
    int n_run = 0;
    int n_fail = 0;

    assign sn = {tmark_seen, burst_seen, noise_seen};

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_pattern_detect dut (
        .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .half_tick(half_tick),
        .write_mode(write_mode), .dens_6250(dens_6250), .dens_1600(dens_1600),
        .read_ok(read_ok), .noise_flag(fl[0]), .burst_flag(fl[1]), .tmark_flag(fl[2]),
        .noise_seen(noise_seen), .burst_seen(burst_seen), .tmark_seen(tmark_seen)
    );

    // columns: write, 6250 (1) or 1600 (0), channel (0 noise,1 burst,2 tmark), ticks
    localparam int TV [0:11][0:3] = '{
        '{1, 1, 0,  92}, '{0, 1, 0,  44}, '{1, 0, 0,  46}, '{0, 0, 0,  22},
        '{1, 1, 1,  50}, '{0, 1, 1,  50}, '{1, 0, 1,  25}, '{0, 0, 1,  25},
        '{1, 1, 2, 608}, '{0, 1, 2,  84}, '{1, 0, 2, 168}, '{0, 0, 2,  42}
    };

    task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cell_tick = phase;
            half_tick = ~phase;
            phase = ~phase;
            @(negedge clk);
            cell_tick = 1'b0;
            half_tick = 1'b0;
        end
    endtask

    task automatic rearm;
        @(negedge clk); read_ok = 1'b0; fl = 3'b000;
        @(negedge clk);
        @(negedge clk); read_ok = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        string rq;
        repeat (3) @(negedge clk);
        chk(sn, 3'b000, "R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(sn, 3'b000, "R11 after reset");

        // threshold table: R1 noise, R2 burst, R3 tape-mark; R10 others stay clear
        for (int v = 0; v < 12; v++) begin
            write_mode = TV[v][0][0];
            dens_6250  = TV[v][1][0];
            dens_1600  = ~TV[v][1][0];
            rq = (TV[v][2] == 0) ? "R1" : (TV[v][2] == 1) ? "R2" : "R3";
            rearm();
            fl = 3'b000;
            fl[TV[v][2]] = 1'b1;
            ticks(TV[v][3] - 1);
            @(negedge clk);
            chk(sn, 3'b000, {rq, " one short"});
            ticks(1);
            chk(sn, fl, {rq, "/R9/R10 on threshold"});
        end

        // R7: a break restarts the run (burst, write 6250 = 50 ticks)
        write_mode = 1'b1; dens_6250 = 1'b1; dens_1600 = 1'b0;
        rearm();
        fl = 3'b010;
        ticks(49);
        @(negedge clk); fl = 3'b000;
        @(negedge clk); fl = 3'b010;
        ticks(49);
        @(negedge clk);
        chk(sn, 3'b000, "R7 restart after break");
        ticks(1);
        chk(sn, 3'b010, "R7 full run after break");

        // R5: sticky after flag drops
        fl = 3'b000;
        ticks(5);
        chk(sn, 3'b010, "R5 sticky");

        // R4: read_ok low clears and blocks
        @(negedge clk); read_ok = 1'b0;
        @(negedge clk);
        chk(sn, 3'b000, "R4 cleared");
        fl = 3'b111;
        ticks(700);
        chk(sn, 3'b000, "R4 held clear");
        fl = 3'b000;

        // R6: no density selected (800 BPI)
        write_mode = 1'b0; dens_6250 = 1'b0; dens_1600 = 1'b0;
        rearm();
        fl = 3'b111;
        ticks(700);
        chk(sn, 3'b000, "R6 no set in 800 BPI");

        // R8: both density bits -> 6250 read noise = 44 ticks
        dens_6250 = 1'b1; dens_1600 = 1'b1;
        rearm();
        fl = 3'b001;
        ticks(43);
        @(negedge clk);
        chk(sn, 3'b000, "R8 both bits one short");
        ticks(1);
        chk(sn, 3'b001, "R8 both bits on threshold");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule